// File: doc/BRIEF.md
# Host Port Register Slave

This block gives an external processor access to a word-addressed RAM inside the chip without any help from the local logic. The host sees only three 32-bit registers: a control register, an address register and a data register. A 2-bit select picks the register for each host cycle. Reading or writing the data register moves a word between the host and the RAM at the location held in the address register. One select code advances that address after each complete data access, so block transfers need no address rewrites.

The host bus runs 16 or 32 bits wide. A strap input, sampled while reset is held, fixes the width until the next reset. In the narrow mode every 32-bit register access takes two host cycles, and a half-select input marks which half each cycle carries. The same pins serve other functions on the chip. Two enable straps, latched during reset, decide whether this port owns them. Local logic can flag the host through an interrupt, and the host acknowledges it through the control register.

Host cycles are synchronous to `clk`. A cycle completes on the rising edge where `hcs` and `hrdy` are both high. The host holds its select, direction, half and write data steady until then.

Top module: `hostport_slave`

## Requirements
- R1: While `rst_n` is low the block samples `cfg_w32` (1 = 32-bit bus, 0 = 16-bit bus) and the enables `en_a` and `en_b`. The port is selected only when both enables were low. These settings hold unchanged from reset release to the next reset.
- R2: `hsel` encoding: 2'b00 control, 2'b01 address, 2'b10 data with address post-increment, 2'b11 data with the address left unchanged.
- R3: A completed data-register write stores the word in RAM at the address register's low `AW` bits. With `hsel`=2'b10 the address register then reads one higher. With 2'b11 it is unchanged.
- R4: A data-register read (first half in 16-bit mode) fetches the RAM word at the current address. `hrdy` is low for exactly two cycles after the host presents the read, then the fetched word appears on `hdout`. With `hsel`=2'b10 the address advances by one after the read completes.
- R5: In 16-bit mode `hhalf`=0 carries bits 15:0 and `hhalf`=1 carries bits 31:16 on `hdin[15:0]`/`hdout[15:0]`. `hdout[31:16]` reads zero. The RAM write and any address increment happen only after the `hhalf`=1 cycle. A high-half data read returns the word already fetched and costs no wait cycles.
- R6: A cycle with `local_irq` high while the port is selected sets control bit 0 and drives `hint` high from the next cycle.
- R7: A host write with control bit 0 set clears the flag and drops `hint`. Writing 0 there leaves the flag set. A set in the same cycle wins over a clear.
- R8: Control bit 1 reads the latched width (1 = 32-bit). All other control bits read zero, and host writes do not change them.
- R9: When the port is not selected, `hrdy` and `hint` stay low and host cycles change neither registers nor RAM.
- R10: After reset the address register and the interrupt flag are zero, and with the port selected and no access pending `hrdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps are sampled while low |
| cfg_w32 | input | 1 | Width strap: 1 = 32-bit host bus, 0 = 16-bit |
| en_a | input | 1 | Pin-sharing enable strap A (low to select this port) |
| en_b | input | 1 | Pin-sharing enable strap B (low to select this port) |
| hcs | input | 1 | Host cycle strobe |
| hsel | input | 2 | Register select |
| hrw | input | 1 | 1 = host read, 0 = host write |
| hhalf | input | 1 | Half select in 16-bit mode (0 = low, 1 = high) |
| hdin | input | 32 | Host write data |
| hdout | output | 32 | Host read data |
| hrdy | output | 1 | Ready; a cycle completes when `hcs` and `hrdy` are high |
| hint | output | 1 | Interrupt to the host |
| local_irq | input | 1 | Local request to raise the host interrupt |

## Verification
The assertions take for granted that the host holds `hcs`, `hsel`, `hrw`, `hhalf` and `hdin` steady from presenting a cycle until `hrdy` completes it. They also assume that in 16-bit mode a low-half data read is always followed by its high-half partner before another fetch. The wait-state property further assumes `hrdy` was high in the cycle before a fetch is launched. This holds because the host only opens a new cycle after the previous one completed or while idle. The bench drives every input on the falling edge. Its access task keeps each cycle presented until ready, and it always issues halves in low-then-high order, so the stimulus stays inside these assumptions.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_ADDR = 2'b01,
        SEL_DINC = 2'b10,
        SEL_DFIX = 2'b11
    } hp_sel_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'b00,
        FS_WAIT = 2'b01,
        FS_HAVE = 2'b10
    } hp_fetch_e;

    localparam int REG_W      = 32;
    localparam int HALF_W     = REG_W / 2;
    localparam int CTRL_FLAG  = 0;
    localparam int CTRL_WIDTH = 1;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
        logic             flag;
        hp_fetch_e        fst;
    } hp_core_s;

    typedef struct packed {
        logic w32;
        logic on;
    } hp_strap_s;

    // Combine a host write into a register value according to bus width and half.
    function automatic logic [REG_W-1:0] hp_merge(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] wd,
                                                   input logic             w32,
                                                   input logic             hi);
        logic [REG_W-1:0] res;
        if (w32) begin
            res = wd;
        end else if (hi) begin
            res = {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
        end else begin
            res = {old_v[REG_W-1:HALF_W], wd[HALF_W-1:0]};
        end
        return res;
    endfunction

endpackage

// File: rtl/hp_strap.sv
module hp_strap
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_w32,
    input  logic en_a,
    input  logic en_b,
    output logic w32,
    output logic port_on
);

    hp_strap_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!rst_n) begin
            s_d.w32 = cfg_w32;
            s_d.on  = ~en_a & ~en_b;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign w32     = s_q.w32;
    assign port_on = s_q.on;

endmodule

// File: rtl/hp_ram.sv
module hp_ram #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[addr] <= wdata;
            end else begin
                rdata_q <= mem_q[addr];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hp_core.sv
module hp_core
    import hp_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w32,
    input  logic             port_on,
    input  logic             hcs,
    input  logic [1:0]       hsel,
    input  logic             hrw,
    input  logic             hhalf,
    input  logic [REG_W-1:0] hdin,
    input  logic             local_irq,
    output logic [REG_W-1:0] hdout,
    output logic             hrdy,
    output logic             hint,
    output logic             ram_en,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [REG_W-1:0] ram_wdata,
    input  logic [REG_W-1:0] ram_rdata
);

    hp_core_s         r_d, r_q;
    hp_sel_e          sel;
    logic             first_half;
    logic             last_half;
    logic             need_fetch;
    logic             rdy_c;
    logic             acc;
    logic [REG_W-1:0] ctrl_v;
    logic [REG_W-1:0] rd_v;
    logic [REG_W-1:0] merged;

    always_comb begin
        sel        = hp_sel_e'(hsel);
        first_half = w32 | ~hhalf;
        last_half  = w32 | hhalf;
        need_fetch = hcs & hrw & hsel[1] & first_half;

        unique case (r_q.fst)
            FS_IDLE: rdy_c = ~need_fetch;
            FS_HAVE: rdy_c = 1'b1;
            default: rdy_c = 1'b0;
        endcase
        hrdy = port_on & rdy_c;
        acc  = hcs & hrdy;

        merged = hp_merge((sel == SEL_ADDR) ? r_q.addr : r_q.data, hdin, w32, hhalf);

        r_d       = r_q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = r_q.addr[AW-1:0];
        ram_wdata = merged;

        // Fetch sequencing for data reads
        unique case (r_q.fst)
            FS_IDLE: begin
                if (port_on && need_fetch) begin
                    ram_en    = 1'b1;
                    r_d.fst   = FS_WAIT;
                end
            end
            FS_WAIT: begin
                r_d.data = ram_rdata;
                r_d.fst  = FS_HAVE;
            end
            FS_HAVE: begin
                if (!hcs || acc) begin
                    r_d.fst = FS_IDLE;
                end
            end
            default: r_d.fst = FS_IDLE;
        endcase

        // Completed host cycles
        if (acc) begin
            if (!hrw) begin
                unique case (sel)
                    SEL_CTRL: begin
                        if (first_half && hdin[CTRL_FLAG]) begin
                            r_d.flag = 1'b0;
                        end
                    end
                    SEL_ADDR: r_d.addr = merged;
                    default: begin
                        r_d.data = merged;
                        if (last_half) begin
                            ram_en = 1'b1;
                            ram_we = 1'b1;
                            if (sel == SEL_DINC) begin
                                r_d.addr = r_q.addr + 1'b1;
                            end
                        end
                    end
                endcase
            end else if (sel == SEL_DINC && last_half) begin
                r_d.addr = r_q.addr + 1'b1;
            end
        end

        // Local set has priority over a host clear
        if (port_on && local_irq) begin
            r_d.flag = 1'b1;
        end

        // Read data path
        ctrl_v             = '0;
        ctrl_v[CTRL_FLAG]  = r_q.flag;
        ctrl_v[CTRL_WIDTH] = w32;
        unique case (sel)
            SEL_CTRL: rd_v = ctrl_v;
            SEL_ADDR: rd_v = r_q.addr;
            default:  rd_v = r_q.data;
        endcase
        if (!port_on) begin
            hdout = '0;
        end else if (w32) begin
            hdout = rd_v;
        end else begin
            hdout = {{HALF_W{1'b0}}, hhalf ? rd_v[REG_W-1:HALF_W] : rd_v[HALF_W-1:0]};
        end

        hint = r_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
    import hp_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_w32,
    input  logic        en_a,
    input  logic        en_b,
    input  logic        hcs,
    input  logic [1:0]  hsel,
    input  logic        hrw,
    input  logic        hhalf,
    input  logic [31:0] hdin,
    output logic [31:0] hdout,
    output logic        hrdy,
    output logic        hint,
    input  logic        local_irq
);

    logic             w32;
    logic             port_on;
    logic             ram_en;
    logic             ram_we;
    logic [AW-1:0]    ram_addr;
    logic [REG_W-1:0] ram_wdata;
    logic [REG_W-1:0] ram_rdata;

    hp_strap u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_w32 (cfg_w32),
        .en_a    (en_a),
        .en_b    (en_b),
        .w32     (w32),
        .port_on (port_on)
    );

    hp_core #(.AW(AW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .w32       (w32),
        .port_on   (port_on),
        .hcs       (hcs),
        .hsel      (hsel),
        .hrw       (hrw),
        .hhalf     (hhalf),
        .hdin      (hdin),
        .local_irq (local_irq),
        .hdout     (hdout),
        .hrdy      (hrdy),
        .hint      (hint),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    hp_ram #(.AW(AW), .DW(REG_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/hp_checker.sv
module hp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        w32,
    input logic        port_on,
    input logic        hcs,
    input logic [1:0]  hsel,
    input logic        hrw,
    input logic        hhalf,
    input logic [31:0] hdin,
    input logic [31:0] hdout,
    input logic        hrdy,
    input logic        hint,
    input logic        local_irq
);

    // R1: latched width does not move between resets
    p_width_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(w32));

    // R4: a freshly launched fetch keeps ready low for a second cycle
    p_fetch_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_on && !hrdy && $past(hrdy)) |=> !hrdy);

    // R5: narrow mode leaves the upper read lanes at zero
    p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !w32 |-> (hdout[31:16] == 16'h0000));

    // R6: a local request raises the host interrupt
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_on && local_irq) |=> hint);

    // R7: host write-one to the flag clears it when no new request arrives
    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hcs && hrdy && !hrw && hsel == 2'b00 && (w32 || !hhalf) && hdin[0] && !local_irq)
        |=> !hint);

    // R8: control read in wide mode shows only the width bit and the flag
    p_ctrl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hcs && hrdy && hrw && hsel == 2'b00 && w32) |-> (hdout[31:2] == 30'h0 && hdout[1]));

    // R9: an unselected port never signals ready or interrupt
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on |-> (!hrdy && !hint));

endmodule

bind hostport_slave hp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .w32       (w32),
    .port_on   (port_on),
    .hcs       (hcs),
    .hsel      (hsel),
    .hrw       (hrw),
    .hhalf     (hhalf),
    .hdin      (hdin),
    .hdout     (hdout),
    .hrdy      (hrdy),
    .hint      (hint),
    .local_irq (local_irq)
);

// File: tb/test_hostport_slave.sv
`timescale 1ns/1ps
module test_hostport_slave;

    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_w32 = 1'b1;
    logic        en_a = 1'b0;
    logic        en_b = 1'b0;
    logic        hcs = 1'b0;
    logic [1:0]  hsel = 2'b00;
    logic        hrw = 1'b0;
    logic        hhalf = 1'b0;
    logic [31:0] hdin = '0;
    logic [31:0] hdout;
    logic        hrdy;
    logic        hint;
    logic        local_irq = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hostport_slave #(.AW(AW)) i_hostport_slave (
        .clk(clk), .rst_n(rst_n), .cfg_w32(cfg_w32), .en_a(en_a), .en_b(en_b),
        .hcs(hcs), .hsel(hsel), .hrw(hrw), .hhalf(hhalf), .hdin(hdin),
        .hdout(hdout), .hrdy(hrdy), .hint(hint), .local_irq(local_irq)
    );

    function automatic logic [31:0] pat(input int i);
        return ((i + 1) * 32'h01030507) ^ 32'h5A5A0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic w, input logic a, input logic b);
        rst_n   = 1'b0;
        cfg_w32 = w;
        en_a    = a;
        en_b    = b;
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
        cfg_w32 = ~w;
        en_a    = ~a;
        en_b    = ~b;
        #1;
    endtask

    // One host cycle, called at a falling edge; returns at a falling edge.
    task automatic acc(input logic [1:0] s, input logic rw, input logic hf,
                       input logic [31:0] wd, output logic [31:0] rd, output int waits);
        hcs = 1'b1; hsel = s; hrw = rw; hhalf = hf; hdin = wd;
        waits = 0;
        #1;
        while (!hrdy && waits < 20) begin
            @(negedge clk);
            #1;
            waits++;
        end
        if (!hrdy) chk("timeout", 32'd0, 32'd1);
        rd = hdout;
        @(negedge clk);
        hcs = 1'b0;
    endtask

    task automatic wr32(input logic [1:0] s, input logic [31:0] v);
        logic [31:0] rd; int w;
        acc(s, 1'b0, 1'b0, v, rd, w);
    endtask

    task automatic rd32(input logic [1:0] s, output logic [31:0] v, output int w);
        acc(s, 1'b1, 1'b0, 32'h0, v, w);
    endtask

    task automatic wr16(input logic [1:0] s, input logic [31:0] v);
        logic [31:0] rd; int w;
        acc(s, 1'b0, 1'b0, {16'h0, v[15:0]}, rd, w);
        acc(s, 1'b0, 1'b1, {16'h0, v[31:16]}, rd, w);
    endtask

    task automatic rd16(input logic [1:0] s, output logic [31:0] v, output int wlo, output int whi);
        logic [31:0] lo, hi;
        acc(s, 1'b1, 1'b0, 32'h0, lo, wlo);
        acc(s, 1'b1, 1'b1, 32'h0, hi, whi);
        chk("R5 upper lanes zero", {lo[31:16], hi[31:16]}, 32'h0);
        v = {hi[15:0], lo[15:0]};
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int w, w2;

        // ---------------- 32-bit mode ----------------
        do_reset(1'b1, 1'b0, 1'b0);
        chk("R10 ready after reset", {31'h0, hrdy}, 32'h1);
        chk("R10 hint after reset", {31'h0, hint}, 32'h0);
        rd32(2'b01, v, w);
        chk("R10 address zero", v, 32'h0);
        rd32(2'b00, v, w);
        chk("R8 R1 control shows wide mode", v, 32'h2);

        wr32(2'b01, 32'h0);
        for (int i = 0; i < WORDS; i++) wr32(2'b10, pat(i));
        rd32(2'b01, v, w);
        chk("R3 address after incrementing writes", v, WORDS);

        wr32(2'b01, 32'h0);
        for (int i = 0; i < WORDS; i++) begin
            rd32(2'b10, v, w);
            chk("R4 read data", v, pat(i));
            chk("R4 wait cycles", w, 2);
        end
        rd32(2'b01, v, w);
        chk("R4 address after incrementing reads", v, WORDS);

        wr32(2'b01, 32'h3);
        wr32(2'b11, 32'hDEADBEEF);
        rd32(2'b01, v, w);
        chk("R2 fixed-select write keeps address", v, 32'h3);
        rd32(2'b11, v, w);
        chk("R2 fixed-select read data", v, 32'hDEADBEEF);
        rd32(2'b01, v, w);
        chk("R2 fixed-select read keeps address", v, 32'h3);
        wr32(2'b01, 32'h2);
        rd32(2'b11, v, w);
        chk("R3 neighbour word intact", v, pat(2));

        // interrupt
        local_irq = 1'b1; @(negedge clk); local_irq = 1'b0; #1;
        chk("R6 hint raised", {31'h0, hint}, 32'h1);
        rd32(2'b00, v, w);
        chk("R6 flag bit visible", v, 32'h3);
        wr32(2'b00, 32'hFFFFFFFE);
        chk("R7 writing zero keeps flag", {31'h0, hint}, 32'h1);
        rd32(2'b00, v, w);
        chk("R8 other control bits not writable", v, 32'h3);
        wr32(2'b00, 32'h1);
        #1;
        chk("R7 write one clears", {31'h0, hint}, 32'h0);
        // set and clear in the same cycle: set wins
        local_irq = 1'b1;
        wr32(2'b00, 32'h1);
        local_irq = 1'b0;
        #1;
        chk("R7 set beats clear", {31'h0, hint}, 32'h1);
        wr32(2'b00, 32'h1);

        // ---------------- 16-bit mode ----------------
        do_reset(1'b0, 1'b0, 1'b0);
        rd16(2'b00, v, w, w2);
        chk("R1 R8 control shows narrow mode", v, 32'h0);
        wr16(2'b01, 32'h0);
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] rd; int ww;
            acc(2'b10, 1'b0, 1'b0, {16'h0, pat(i)[15:0] ^ 16'h00FF}, rd, ww);
            rd16(2'b01, v, w, w2);
            chk("R5 no increment after low half", v, i);
            acc(2'b10, 1'b0, 1'b1, {16'h0, pat(i)[31:16] ^ 16'hFF00}, rd, ww);
        end
        rd16(2'b01, v, w, w2);
        chk("R5 address after narrow writes", v, WORDS);
        wr16(2'b01, 32'h0);
        for (int i = 0; i < WORDS; i++) begin
            rd16(2'b10, v, w, w2);
            chk("R5 narrow read data", v, pat(i) ^ 32'hFF0000FF);
            chk("R5 low half waits", w, 2);
            chk("R5 high half no wait", w2, 0);
        end
        rd16(2'b01, v, w, w2);
        chk("R5 address after narrow reads", v, WORDS);

        // ---------------- port not selected ----------------
        do_reset(1'b1, 1'b1, 1'b0);
        chk("R9 ready low when unselected", {31'h0, hrdy}, 32'h0);
        hcs = 1'b1; hsel = 2'b11; hrw = 1'b0; hhalf = 1'b0; hdin = 32'h12345678;
        local_irq = 1'b1;
        repeat (4) @(negedge clk);
        hsel = 2'b01;
        repeat (2) @(negedge clk);
        hcs = 1'b0; local_irq = 1'b0; #1;
        chk("R9 hint low when unselected", {31'h0, hint}, 32'h0);
        chk("R9 ready still low", {31'h0, hrdy}, 32'h0);
        do_reset(1'b1, 1'b0, 1'b1);
        chk("R9 enable B also deselects", {31'h0, hrdy}, 32'h0);

        do_reset(1'b1, 1'b0, 1'b0);
        rd32(2'b11, v, w);
        chk("R9 RAM untouched by ignored write", v, pat(0) ^ 32'hFF0000FF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule